// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel LCD panel. The horizontal and vertical axes are each set up with four lengths: sync, back porch, active and front porch. From these the block drives horizontal and vertical sync, a data-enable strobe and the pixel coordinates of the visible image. The visible image can be narrower than the hardware active area and can sit at an offset inside it. The offset comes from an X shift and a Y shift. A scaled width limits the visible image horizontally. Vertically the visible height equals the active line count.

The live horizontal and vertical counters are brought out so that software can see where the raster is. A pulse at the start of each vertical sync can serve as a frame interrupt.

A two-bit enable field gates the whole generator. The block captures its timing and window settings only while it is idle or on the last pixel of a frame. Settings that change in the middle of a frame therefore take effect at the next frame. Pixel fetch, scaling and clock generation are outside this block.

Top module: `lcd_timing_gen`

## Requirements
- R1: The generator runs only while `cfg_enable` equals 2'b11. Running starts one clock after that value is first seen. While it is not running, `hpos` and `vpos` are 0 and `hsync`, `vsync`, `de` and `frame_irq` are inactive. This is also the state after reset.
- R2: While running, `hpos` steps by one every clock from 0 up to HT-1 and then returns to 0, where HT is the sum of the four horizontal lengths. On each such return, `vpos` steps by one from 0 up to VT-1 and then returns to 0, where VT is the sum of the four vertical lengths.
- R3: Each axis starts its period in sync, followed by back porch, active, and front porch. `hsync` is high exactly while `hpos` < sync length, and `vsync` is high exactly while `vpos` < vertical sync length. Both are active-high with the default polarity.
- R4: The horizontal active region is `hpos` in [hsync+hback, hsync+hback+hact), and the vertical active region is defined the same way. With zero shifts and a scaled width at least the active width, `de` covers exactly the product of the two active regions.
- R5: Let ax and ay be the offsets of `hpos` and `vpos` into their active regions. `de` is high only inside both active regions, and only when ax >= `x_shift`, ax-`x_shift` < `x_scaled`, ay >= `y_shift` and ay-`y_shift` < vertical active length.
- R6: When `de` is high, `pix_x` = ax-`x_shift` and `pix_y` = ay-`y_shift`. When `de` is low, both are 0.
- R7: All lengths, shifts and the scaled width are captured while idle and on the clock where `hpos`=HT-1 and `vpos`=VT-1. A change at any other time has no effect until the next frame starts.
- R8: `frame_irq` is high for exactly the one clock of each running frame in which `hpos`=0 and `vpos`=0, which is the first clock of vertical sync.
- R9: `hpos` and `vpos` always show the generator's live counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 2 | Run field; 2'b11 runs |
| h_sync_len | input | CW | Horizontal sync length |
| h_back_len | input | CW | Horizontal back porch |
| h_act_len | input | CW | Horizontal active length |
| h_front_len | input | CW | Horizontal front porch |
| v_sync_len | input | CW | Vertical sync length (lines) |
| v_back_len | input | CW | Vertical back porch |
| v_act_len | input | CW | Vertical active lines |
| v_front_len | input | CW | Vertical front porch |
| x_shift | input | CW | Horizontal offset of visible image |
| y_shift | input | CW | Vertical offset of visible image |
| x_scaled | input | CW | Visible image width |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | CW | Visible pixel column |
| pix_y | output | CW | Visible pixel row |
| hpos | output | CW+2 | Live horizontal counter |
| vpos | output | CW+2 | Live vertical counter |
| frame_irq | output | 1 | One-clock pulse at frame start |

## Verification
The hardest case to reach from the ports is a settings change in the middle of a running frame. The check must show that the change stays invisible until the frame boundary, and it depends on which pixel the raster is on when the inputs move. The stimulus rewrites the active width and both shifts at a point inside an active line. It then compares every output, clock by clock, with a reference that only adopts new settings at the last pixel of the frame. Shift values are swept frame by frame so that the visible window lands at the left edge and at the right edge, and clips at the right edge. The generator is also disabled part-way through a frame and then restarted.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } tg_phase_e;

   localparam logic [1:0] TG_RUN_CODE = 2'b11;
endpackage

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
   import lcd_tg_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          step,
   input  logic          load,
   input  logic [CW-1:0] sync_len,
   input  logic [CW-1:0] back_len,
   input  logic [CW-1:0] act_len,
   input  logic [CW-1:0] front_len,
   output logic [CW+1:0] cnt,
   output logic          last,
   output tg_phase_e     phase,
   output logic [CW-1:0] act_off,
   output logic [CW-1:0] act_len_q
);
   localparam int PW = CW + 2;

   logic [CW-1:0] sync_q, back_q, front_q;
   logic [PW-1:0] act_start, act_end, total;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q    <= '0;
         back_q    <= '0;
         act_len_q <= '0;
         front_q   <= '0;
      end else if (load) begin
         sync_q    <= sync_len;
         back_q    <= back_len;
         act_len_q <= act_len;
         front_q   <= front_len;
      end
   end

   assign act_start = PW'(sync_q) + PW'(back_q);
   assign act_end   = act_start + PW'(act_len_q);
   assign total     = act_end + PW'(front_q);
   assign last      = (cnt == total - PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (step)    cnt <= last ? '0 : cnt + PW'(1);
   end

   always_comb begin
      if (cnt < PW'(sync_q))   phase = PH_SYNC;
      else if (cnt < act_start) phase = PH_BACK;
      else if (cnt < act_end)   phase = PH_ACT;
      else                      phase = PH_FRONT;
   end

   assign act_off = CW'(cnt - act_start);

   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0)); // R1
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (run && step && last) |=> (cnt == '0)); // R2
endmodule

// File: rtl/lcd_tg_window.sv
module lcd_tg_window
   import lcd_tg_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  tg_phase_e     hphase,
   input  tg_phase_e     vphase,
   input  logic [CW-1:0] hoff,
   input  logic [CW-1:0] voff,
   input  logic [CW-1:0] hlen,
   input  logic [CW-1:0] vlen,
   input  logic [CW-1:0] xs,
   input  logic [CW-1:0] ys,
   input  logic [CW-1:0] xsc,
   output logic          de,
   output logic [CW-1:0] px,
   output logic [CW-1:0] py
);
   logic [CW-1:0] xrel, yrel;
   logic          x_in, y_in;

   assign xrel = hoff - xs;
   assign yrel = voff - ys;
   assign x_in = (hphase == PH_ACT) && (hoff >= xs) && (xrel < xsc) && (hoff < hlen);
   assign y_in = (vphase == PH_ACT) && (voff >= ys) && (yrel < vlen);
   assign de   = run && x_in && y_in;
   assign px   = de ? xrel : '0;
   assign py   = de ? yrel : '0;

   AST_DE_INSIDE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (hphase == PH_ACT && vphase == PH_ACT)); // R5
   AST_PIX_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> (px == '0 && py == '0)); // R6
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcd_tg_pkg::*;
#(
   parameter int CW        = 12,
   parameter bit SYNC_HIGH = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cfg_enable,
   input  logic [CW-1:0] h_sync_len,
   input  logic [CW-1:0] h_back_len,
   input  logic [CW-1:0] h_act_len,
   input  logic [CW-1:0] h_front_len,
   input  logic [CW-1:0] v_sync_len,
   input  logic [CW-1:0] v_back_len,
   input  logic [CW-1:0] v_act_len,
   input  logic [CW-1:0] v_front_len,
   input  logic [CW-1:0] x_shift,
   input  logic [CW-1:0] y_shift,
   input  logic [CW-1:0] x_scaled,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [CW-1:0] pix_x,
   output logic [CW-1:0] pix_y,
   output logic [CW+1:0] hpos,
   output logic [CW+1:0] vpos,
   output logic          frame_irq
);
   localparam int PW = CW + 2;

   generate
      if (CW < 4 || CW > 16) begin : g_bad_cw
         $error("lcd_timing_gen: CW must lie in 4..16");
      end
   endgenerate

   logic          armed_q, run_eff, load;
   logic          h_last, v_last;
   tg_phase_e     h_ph, v_ph;
   logic [CW-1:0] h_off, v_off, h_len_q, v_len_q;
   logic [CW-1:0] xs_q, ys_q, xsc_q;
   logic          hs_raw, vs_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= (cfg_enable == TG_RUN_CODE);
   end

   assign run_eff = (cfg_enable == TG_RUN_CODE) && armed_q;
   assign load    = !run_eff || (h_last && v_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xs_q  <= '0;
         ys_q  <= '0;
         xsc_q <= '0;
      end else if (load) begin
         xs_q  <= x_shift;
         ys_q  <= y_shift;
         xsc_q <= x_scaled;
      end
   end

   lcd_tg_axis #(.CW(CW)) u_hax (
      .clk(clk), .rst_n(rst_n), .run(run_eff), .step(1'b1), .load(load),
      .sync_len(h_sync_len), .back_len(h_back_len),
      .act_len(h_act_len), .front_len(h_front_len),
      .cnt(hpos), .last(h_last), .phase(h_ph), .act_off(h_off), .act_len_q(h_len_q)
   );

   lcd_tg_axis #(.CW(CW)) u_vax (
      .clk(clk), .rst_n(rst_n), .run(run_eff), .step(h_last), .load(load),
      .sync_len(v_sync_len), .back_len(v_back_len),
      .act_len(v_act_len), .front_len(v_front_len),
      .cnt(vpos), .last(v_last), .phase(v_ph), .act_off(v_off), .act_len_q(v_len_q)
   );

   lcd_tg_window #(.CW(CW)) u_win (
      .clk(clk), .rst_n(rst_n), .run(run_eff),
      .hphase(h_ph), .vphase(v_ph), .hoff(h_off), .voff(v_off),
      .hlen(h_len_q), .vlen(v_len_q),
      .xs(xs_q), .ys(ys_q), .xsc(xsc_q),
      .de(de), .px(pix_x), .py(pix_y)
   );

   assign hs_raw    = run_eff && (h_ph == PH_SYNC);
   assign vs_raw    = run_eff && (v_ph == PH_SYNC);
   assign frame_irq = run_eff && (hpos == PW'(0)) && (vpos == PW'(0));

   generate
      if (SYNC_HIGH) begin : g_pol_high
         assign hsync = hs_raw;
         assign vsync = vs_raw;
      end else begin : g_pol_low
         assign hsync = !hs_raw;
         assign vsync = !vs_raw;
      end
   endgenerate

   AST_IRQ_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      frame_irq |-> (vs_raw && hpos == PW'(0))); // R8
   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_irq && !h_last) |=> !frame_irq); // R8
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_eff && !(h_last && v_last)) |=> ($stable(xs_q) && $stable(xsc_q))); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run_eff |-> (!de && !frame_irq && !hs_raw && !vs_raw)); // R1
endmodule

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;
   localparam int CW = 12;
   localparam int PW = CW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_enable = 2'b00;
   logic [CW-1:0] h_sync_len = 2, h_back_len = 3, h_act_len = 6, h_front_len = 2;
   logic [CW-1:0] v_sync_len = 1, v_back_len = 2, v_act_len = 4, v_front_len = 1;
   logic [CW-1:0] x_shift = 1, y_shift = 1, x_scaled = 4;
   logic          hsync, vsync, de, frame_irq;
   logic [CW-1:0] pix_x, pix_y;
   logic [PW-1:0] hpos, vpos;

   int checks = 0, fails = 0, cycles = 0;
   string tag_ovr = "";

   always #2.5 clk = ~clk;

   lcd_timing_gen #(.CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
      .h_sync_len(h_sync_len), .h_back_len(h_back_len), .h_act_len(h_act_len), .h_front_len(h_front_len),
      .v_sync_len(v_sync_len), .v_back_len(v_back_len), .v_act_len(v_act_len), .v_front_len(v_front_len),
      .x_shift(x_shift), .y_shift(y_shift), .x_scaled(x_scaled),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
      .hpos(hpos), .vpos(vpos), .frame_irq(frame_irq)
   );

   // reference model state, built from the requirements
   int  mh = 0, mv = 0;
   bit  armed = 0;
   int  s_hs, s_hb, s_ha, s_hf, s_vs, s_vb, s_va, s_vf, s_xs, s_ys, s_xsc;

   always @(posedge clk) begin
      if (!rst_n) begin
         mh = 0; mv = 0; armed = 0;
         s_hs = 0; s_hb = 0; s_ha = 0; s_hf = 0; s_vs = 0; s_vb = 0; s_va = 0; s_vf = 0;
         s_xs = 0; s_ys = 0; s_xsc = 0;
      end else begin
         automatic bit re = (cfg_enable == 2'b11) && armed;
         automatic int ht = s_hs + s_hb + s_ha + s_hf;
         automatic int vt = s_vs + s_vb + s_va + s_vf;
         automatic bit frame_end = (mh == ht - 1) && (mv == vt - 1);
         if (!re || frame_end) begin // R7 capture points
            s_hs = h_sync_len; s_hb = h_back_len; s_ha = h_act_len; s_hf = h_front_len;
            s_vs = v_sync_len; s_vb = v_back_len; s_va = v_act_len; s_vf = v_front_len;
            s_xs = x_shift; s_ys = y_shift; s_xsc = x_scaled;
         end
         if (!re) begin mh = 0; mv = 0; end
         else if (mh == ht - 1) begin mh = 0; mv = (mv == vt - 1) ? 0 : mv + 1; end
         else mh = mh + 1;
         armed = (cfg_enable == 2'b11);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog expired: actual %0d cycles expected < 150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(string req, int act, int exp, string what);
      string r;
      r = (tag_ovr != "") ? tag_ovr : req;
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (hpos model %0d vpos model %0d)",
                  r, what, act, exp, mh, mv);
      end
   endtask

   task automatic check_all(string de_tag);
      bit re, hact, vact, e_de;
      int ax, ay;
      re   = (cfg_enable == 2'b11) && armed;
      hact = mh >= s_hs + s_hb && mh < s_hs + s_hb + s_ha;
      vact = mv >= s_vs + s_vb && mv < s_vs + s_vb + s_va;
      ax   = mh - (s_hs + s_hb);
      ay   = mv - (s_vs + s_vb);
      e_de = re && hact && vact && ax >= s_xs && ax - s_xs < s_xsc && ay >= s_ys && ay - s_ys < s_va;
      chk("R2", int'(hpos), re ? mh : 0, "hpos");
      chk("R9", int'(vpos), re ? mv : 0, "vpos");
      chk("R3", int'(hsync), int'(re && mh < s_hs), "hsync");
      chk("R3", int'(vsync), int'(re && mv < s_vs), "vsync");
      chk(de_tag, int'(de), int'(e_de), "de");
      chk("R6", int'(pix_x), e_de ? ax - s_xs : 0, "pix_x");
      chk("R6", int'(pix_y), e_de ? ay - s_ys : 0, "pix_y");
      chk("R8", int'(frame_irq), int'(re && mh == 0 && mv == 0), "frame_irq");
   endtask

   task automatic cyc(int n, string de_tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #0.5;
         check_all(de_tag);
      end
   endtask

   task automatic to_frame_start(string de_tag);
      do cyc(1, de_tag); while (!(mh == 0 && mv == 0 && armed));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      tag_ovr = "R1";
      check_all("R1");                 // reset state
      rst_n = 1'b1;
      cyc(3, "R1");
      cfg_enable = 2'b01;               // not the run code: idle
      cyc(20, "R1");
      cfg_enable = 2'b10;
      cyc(10, "R1");
      tag_ovr = "";
      cfg_enable = 2'b11;               // run two frames
      cyc(2 * 104 + 3, "R5");
      // sweep shifts, one frame each, changed at frame start
      for (int xs = 0; xs < 4; xs++) begin
         for (int ys = 0; ys < 3; ys++) begin
            @(negedge clk);
            x_shift = xs; y_shift = ys;
            to_frame_start("R5");
            cyc(103, "R5");
         end
      end
      // exact active area with no shift
      @(negedge clk);
      x_shift = 0; y_shift = 0; x_scaled = 40;
      to_frame_start("R4");
      cyc(104, "R4");
      // mid-frame change: must wait for the next frame
      to_frame_start("R5");
      cyc(40, "R5");
      tag_ovr = "R7";
      h_act_len = 8; x_shift = 2; x_scaled = 3; y_shift = 1; v_back_len = 1;
      to_frame_start("R7");
      tag_ovr = "";
      cyc(2 * 106, "R5");
      // disable mid-frame, then restart
      cyc(30, "R5");
      tag_ovr = "R1";
      cfg_enable = 2'b10;
      cyc(12, "R1");
      tag_ovr = "";
      cfg_enable = 2'b11;
      cyc(150, "R5");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule